// File: doc/BRIEF.md
# Source Operand Addressing Decoder

This block takes one 16-bit instruction word of a small orthogonal microcontroller and, with no register in the path, breaks it into its operand fields and says how the source operand is to be reached. It reports the source and destination register numbers, the two source mode bits, the destination mode bit and the operand-size bit. It also gives an eight-way source addressing class: register, indexed, symbolic, absolute, indirect, indirect with post-increment, immediate or generated constant.

Two registers in the file double as constant generators. When either is named as the source with certain mode bits, the operand is a fixed value and no extension word is fetched. The decoder outputs that value with a valid flag. It also states whether the source or the destination needs an extension word after the instruction. It flags a two-operand word that names the constant register as a register-mode destination.

Fetch, execution and status flags stay with the surrounding pipeline. All outputs settle in the same cycle as the input word.

Top module: `asd_source_decode`

## Requirements
- R1: Field split. `dst_reg` is bits 3:0, `src_reg` is bits 11:8, `src_as` is bits 5:4, `dst_ad` is bit 7 and `byte_op` is bit 6 of `insn_word`.
- R2: With source register 3, `src_mode` is 7 (constant) and `const_ok` is 1. `const_val` is 0x0000, 0x0001, 0x0002 and 0xFFFF for `src_as` 00, 01, 10 and 11. `src_ext` is 0.
- R3: With source register 2, `src_as`=10 gives constant 0x0004 and `src_as`=11 gives constant 0x0008. Both give mode 7, `const_ok`=1 and `src_ext`=0.
- R4: With source register 2 and `src_as`=01, `src_mode` is 3 (absolute) and `src_ext` is 1.
- R5: With source register 0, `src_as`=01 gives `src_mode` 2 (symbolic) and `src_as`=11 gives `src_mode` 6 (immediate). Both set `src_ext` to 1.
- R6: Every other source combination decodes by its mode bits. `src_as` 00 gives mode 0 (register), 01 gives 1 (indexed, `src_ext`=1), 10 gives 4 (indirect) and 11 gives 5 (indirect post-increment). Only indexed sets `src_ext`. This includes register 0 with 00 or 10 and register 2 with 00.
- R7: When `src_mode` is not 7, `const_ok` is 0 and `const_val` is 0.
- R8: `dst_ext` equals `dst_ad`, and `src_mode_oh` has exactly bit `src_mode` set.
- R9: `illegal` is 1 exactly when bits 15:12 are 4 or more (two-operand form), `dst_ad` is 0 and `dst_reg` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_word | input | 16 | Instruction word under decode |
| src_reg | output | 4 | Source register number |
| dst_reg | output | 4 | Destination register number |
| src_as | output | 2 | Source mode bits |
| dst_ad | output | 1 | Destination mode bit |
| byte_op | output | 1 | Operand-size bit passed through |
| src_mode | output | 3 | Encoded source addressing class |
| src_mode_oh | output | 8 | One-hot form of the source addressing class |
| const_val | output | 16 | Generated constant value |
| const_ok | output | 1 | Source is a generated constant |
| src_ext | output | 1 | Source needs an extension word |
| dst_ext | output | 1 | Destination needs an extension word |
| illegal | output | 1 | Register-mode destination on the constant register in a two-operand word |

## Verification
The bench walks every one of the 65536 instruction words. Each of the four mode values therefore meets every source register, and each destination register meets both destination modes and every opcode nibble. Registers 0, 2 and 3 show whether the special cases override the generic mode table at exactly the right mode values and nowhere else. The remaining registers show that the generic table holds. Varying the opcode nibble around 4 tells the two-operand illegal check apart from single-operand and jump words that carry the same low bits.

// File: rtl/asd_pkg.sv
package asd_pkg;

  localparam int WORD_W = 16;
  localparam int REG_W  = 4;
  localparam int AS_W   = 2;
  localparam int MODE_W = 3;
  localparam int MODE_N = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    SM_REG   = 3'd0,
    SM_IDX   = 3'd1,
    SM_SYM   = 3'd2,
    SM_ABS   = 3'd3,
    SM_IND   = 3'd4,
    SM_INC   = 3'd5,
    SM_IMM   = 3'd6,
    SM_CONST = 3'd7
  } src_mode_e;

  localparam logic [REG_W-1:0] PC_NUM = 4'd0;
  localparam logic [REG_W-1:0] SR_NUM = 4'd2;
  localparam logic [REG_W-1:0] CG_NUM = 4'd3;

  localparam logic [3:0] DUAL_OPC_MIN = 4'd4;

endpackage

// File: rtl/asd_fields.sv
module asd_fields #(
  parameter int WORD_W = asd_pkg::WORD_W,
  parameter int REG_W  = asd_pkg::REG_W,
  parameter int AS_W   = asd_pkg::AS_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [REG_W-1:0]  src_reg_o,
  output logic [REG_W-1:0]  dst_reg_o,
  output logic [AS_W-1:0]   as_o,
  output logic              ad_o,
  output logic              bw_o,
  output logic [3:0]        opc_o
);

  localparam int DST_LO = 0;
  localparam int AS_LO  = 4;
  localparam int BW_POS = 6;
  localparam int AD_POS = 7;
  localparam int SRC_LO = 8;
  localparam int OPC_LO = WORD_W - 4;

  always_comb begin
    dst_reg_o = word_i[DST_LO +: REG_W];
    as_o      = word_i[AS_LO +: AS_W];
    bw_o      = word_i[BW_POS];
    ad_o      = word_i[AD_POS];
    src_reg_o = word_i[SRC_LO +: REG_W];
    opc_o     = word_i[OPC_LO +: 4];
  end

endmodule

// File: rtl/asd_src_class.sv
module asd_src_class #(
  parameter int              REG_W = asd_pkg::REG_W,
  parameter int              AS_W  = asd_pkg::AS_W,
  parameter logic [REG_W-1:0] PC_R = asd_pkg::PC_NUM,
  parameter logic [REG_W-1:0] SR_R = asd_pkg::SR_NUM,
  parameter logic [REG_W-1:0] CG_R = asd_pkg::CG_NUM
) (
  input  logic [REG_W-1:0]    src_reg_i,
  input  logic [AS_W-1:0]     as_i,
  output asd_pkg::src_mode_e  mode_o,
  output logic                ext_o
);
  import asd_pkg::*;

  logic is_pc;
  logic is_sr;
  logic is_cg;

  always_comb begin
    is_pc = (src_reg_i == PC_R);
    is_sr = (src_reg_i == SR_R);
    is_cg = (src_reg_i == CG_R);

    unique case (as_i)
      2'b00: mode_o = is_cg ? SM_CONST : SM_REG;
      2'b01: begin
        if (is_cg)      mode_o = SM_CONST;
        else if (is_sr) mode_o = SM_ABS;
        else if (is_pc) mode_o = SM_SYM;
        else            mode_o = SM_IDX;
      end
      2'b10: mode_o = (is_cg || is_sr) ? SM_CONST : SM_IND;
      default: begin
        if (is_cg || is_sr) mode_o = SM_CONST;
        else if (is_pc)     mode_o = SM_IMM;
        else                mode_o = SM_INC;
      end
    endcase

    unique case (mode_o)
      SM_IDX, SM_SYM, SM_ABS, SM_IMM: ext_o = 1'b1;
      default:                        ext_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/asd_const_gen.sv
module asd_const_gen #(
  parameter int               WORD_W = asd_pkg::WORD_W,
  parameter int               REG_W  = asd_pkg::REG_W,
  parameter int               AS_W   = asd_pkg::AS_W,
  parameter logic [REG_W-1:0] SR_R   = asd_pkg::SR_NUM,
  parameter logic [REG_W-1:0] CG_R   = asd_pkg::CG_NUM
) (
  input  logic [REG_W-1:0]  src_reg_i,
  input  logic [AS_W-1:0]   as_i,
  output logic [WORD_W-1:0] val_o,
  output logic              ok_o
);

  localparam logic [WORD_W-1:0] K_ZERO  = '0;
  localparam logic [WORD_W-1:0] K_ONE   = WORD_W'(1);
  localparam logic [WORD_W-1:0] K_TWO   = WORD_W'(2);
  localparam logic [WORD_W-1:0] K_FOUR  = WORD_W'(4);
  localparam logic [WORD_W-1:0] K_EIGHT = WORD_W'(8);
  localparam logic [WORD_W-1:0] K_MONE  = {WORD_W{1'b1}};

  always_comb begin
    val_o = K_ZERO;
    ok_o  = 1'b0;
    if (src_reg_i == CG_R) begin
      ok_o = 1'b1;
      unique case (as_i)
        2'b00:   val_o = K_ZERO;
        2'b01:   val_o = K_ONE;
        2'b10:   val_o = K_TWO;
        default: val_o = K_MONE;
      endcase
    end else if (src_reg_i == SR_R && as_i[1]) begin
      ok_o  = 1'b1;
      val_o = as_i[0] ? K_EIGHT : K_FOUR;
    end
  end

endmodule

// File: rtl/asd_dst_check.sv
module asd_dst_check #(
  parameter int               REG_W   = asd_pkg::REG_W,
  parameter logic [REG_W-1:0] CG_R    = asd_pkg::CG_NUM,
  parameter logic [3:0]       OPC_MIN = asd_pkg::DUAL_OPC_MIN
) (
  input  logic [3:0]       opc_i,
  input  logic [REG_W-1:0] dst_reg_i,
  input  logic             ad_i,
  output logic             illegal_o,
  output logic             ext_o
);

  logic dual_form;

  always_comb begin
    dual_form = (opc_i >= OPC_MIN);
    illegal_o = dual_form && !ad_i && (dst_reg_i == CG_R);
    ext_o     = ad_i;
  end

endmodule

// File: rtl/asd_source_decode.sv
module asd_source_decode #(
  parameter int WORD_W = asd_pkg::WORD_W,
  parameter int REG_W  = asd_pkg::REG_W,
  parameter int AS_W   = asd_pkg::AS_W,
  parameter int MODE_W = asd_pkg::MODE_W
) (
  input  logic [WORD_W-1:0]      insn_word,
  output logic [REG_W-1:0]       src_reg,
  output logic [REG_W-1:0]       dst_reg,
  output logic [AS_W-1:0]        src_as,
  output logic                   dst_ad,
  output logic                   byte_op,
  output logic [MODE_W-1:0]      src_mode,
  output logic [(1<<MODE_W)-1:0] src_mode_oh,
  output logic [WORD_W-1:0]      const_val,
  output logic                   const_ok,
  output logic                   src_ext,
  output logic                   dst_ext,
  output logic                   illegal
);
  import asd_pkg::*;

  localparam int MODE_CNT = 1 << MODE_W;

  logic [3:0]      opc;
  src_mode_e       mode_e;
  logic            cls_ext;
  logic [WORD_W-1:0] cg_val;
  logic            cg_ok;

  asd_fields #(
    .WORD_W (WORD_W),
    .REG_W  (REG_W),
    .AS_W   (AS_W)
  ) u_fields (
    .word_i    (insn_word),
    .src_reg_o (src_reg),
    .dst_reg_o (dst_reg),
    .as_o      (src_as),
    .ad_o      (dst_ad),
    .bw_o      (byte_op),
    .opc_o     (opc)
  );

  asd_src_class #(
    .REG_W (REG_W),
    .AS_W  (AS_W)
  ) u_class (
    .src_reg_i (src_reg),
    .as_i      (src_as),
    .mode_o    (mode_e),
    .ext_o     (cls_ext)
  );

  asd_const_gen #(
    .WORD_W (WORD_W),
    .REG_W  (REG_W),
    .AS_W   (AS_W)
  ) u_cgen (
    .src_reg_i (src_reg),
    .as_i      (src_as),
    .val_o     (cg_val),
    .ok_o      (cg_ok)
  );

  asd_dst_check #(
    .REG_W (REG_W)
  ) u_dchk (
    .opc_i     (opc),
    .dst_reg_i (dst_reg),
    .ad_i      (dst_ad),
    .illegal_o (illegal),
    .ext_o     (dst_ext)
  );

  always_comb begin
    src_mode  = mode_e;
    src_ext   = cls_ext;
    const_ok  = cg_ok;
    const_val = cg_val;
  end

  for (genvar gi = 0; gi < MODE_CNT; gi++) begin : g_oh
    assign src_mode_oh[gi] = (src_mode == MODE_W'(gi));
  end

endmodule

// File: rtl/asd_source_decode_chk.sv
module asd_source_decode_chk #(
  parameter int WORD_W = asd_pkg::WORD_W,
  parameter int REG_W  = asd_pkg::REG_W,
  parameter int AS_W   = asd_pkg::AS_W,
  parameter int MODE_W = asd_pkg::MODE_W
) (
  input logic [WORD_W-1:0]      insn_word,
  input logic [REG_W-1:0]       src_reg,
  input logic [AS_W-1:0]        src_as,
  input logic                   dst_ad,
  input logic [MODE_W-1:0]      src_mode,
  input logic [(1<<MODE_W)-1:0] src_mode_oh,
  input logic [WORD_W-1:0]      const_val,
  input logic                   const_ok,
  input logic                   src_ext,
  input logic                   illegal
);

  always_comb begin
    AST_CONST_NO_EXT: assert (!(const_ok && src_ext));                                  // R2
    AST_CONST_REGS: assert (!const_ok || src_reg == 4'd3 || (src_reg == 4'd2 && src_as[1])); // R3
    AST_IMM_SRC: assert (src_mode != 3'd6 || (src_reg == 4'd0 && src_as == 2'b11));      // R5
    AST_EXT_CLASS: assert (!src_ext || src_as == 2'b01 || src_mode == 3'd6);              // R6
    AST_NONCONST_ZERO: assert (const_ok || const_val == '0);                              // R7
    AST_ONEHOT_MODE: assert ($onehot(src_mode_oh));                                       // R8
    AST_ILLEGAL_REGMODE: assert (!illegal || (!dst_ad && insn_word[3:0] == 4'd3));        // R9
  end

endmodule

bind asd_source_decode asd_source_decode_chk #(
  .WORD_W (WORD_W),
  .REG_W  (REG_W),
  .AS_W   (AS_W),
  .MODE_W (MODE_W)
) u_chk (
  .insn_word   (insn_word),
  .src_reg     (src_reg),
  .src_as      (src_as),
  .dst_ad      (dst_ad),
  .src_mode    (src_mode),
  .src_mode_oh (src_mode_oh),
  .const_val   (const_val),
  .const_ok    (const_ok),
  .src_ext     (src_ext),
  .illegal     (illegal)
);

// File: tb/sim_asd_source_decode.sv
module sim_asd_source_decode;

  logic        clk;
  logic        rst_n;
  logic [15:0] insn_word;
  logic [3:0]  src_reg;
  logic [3:0]  dst_reg;
  logic [1:0]  src_as;
  logic        dst_ad;
  logic        byte_op;
  logic [2:0]  src_mode;
  logic [7:0]  src_mode_oh;
  logic [15:0] const_val;
  logic        const_ok;
  logic        src_ext;
  logic        dst_ext;
  logic        illegal;

  int total;
  int bad;
  bit finished;

  asd_source_decode u0 (
    .insn_word   (insn_word),
    .src_reg     (src_reg),
    .dst_reg     (dst_reg),
    .src_as      (src_as),
    .dst_ad      (dst_ad),
    .byte_op     (byte_op),
    .src_mode    (src_mode),
    .src_mode_oh (src_mode_oh),
    .const_val   (const_val),
    .const_ok    (const_ok),
    .src_ext     (src_ext),
    .dst_ext     (dst_ext),
    .illegal     (illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s word=%04h actual=%0h expected=%0h", req, insn_word, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check_word(input logic [15:0] w);
    logic [3:0]  s;
    logic [1:0]  a;
    logic [2:0]  e_mode;
    logic [15:0] e_val;
    logic        e_ok;
    logic        e_ext;
    logic        e_ill;
    string       tag;
    s = w[11:8];
    a = w[5:4];
    e_val = 16'h0000;
    e_ok  = 1'b0;
    if (s == 4'd3) begin
      tag = "R2"; e_mode = 3'd7; e_ok = 1'b1; e_ext = 1'b0;
      case (a)
        2'b00: e_val = 16'h0000;
        2'b01: e_val = 16'h0001;
        2'b10: e_val = 16'h0002;
        default: e_val = 16'hFFFF;
      endcase
    end else if (s == 4'd2 && a[1]) begin
      tag = "R3"; e_mode = 3'd7; e_ok = 1'b1; e_ext = 1'b0;
      e_val = a[0] ? 16'h0008 : 16'h0004;
    end else if (s == 4'd2 && a == 2'b01) begin
      tag = "R4"; e_mode = 3'd3; e_ext = 1'b1;
    end else if (s == 4'd0 && a[0]) begin
      tag = "R5"; e_mode = a[1] ? 3'd6 : 3'd2; e_ext = 1'b1;
    end else begin
      tag = "R6";
      case (a)
        2'b00: e_mode = 3'd0;
        2'b01: e_mode = 3'd1;
        2'b10: e_mode = 3'd4;
        default: e_mode = 3'd5;
      endcase
      e_ext = (a == 2'b01);
    end
    e_ill = (w[15:12] >= 4'd4) && !w[7] && (w[3:0] == 4'd3);

    chk({src_reg, dst_reg, src_as, dst_ad, byte_op} == {w[11:8], w[3:0], w[5:4], w[7], w[6]},
        "R1", {src_reg, dst_reg, src_as, dst_ad, byte_op},
        {w[11:8], w[3:0], w[5:4], w[7], w[6]});
    chk(src_mode == e_mode, tag, src_mode, e_mode);
    chk(src_ext == e_ext, tag, src_ext, e_ext);
    if (e_ok) begin
      chk(const_ok && const_val == e_val, tag, {const_ok, const_val}, {1'b1, e_val});
    end else begin
      chk(!const_ok && const_val == 16'h0000, "R7", {const_ok, const_val}, 17'h0);
    end
    chk(dst_ext == w[7] && src_mode_oh == (8'd1 << e_mode), "R8",
        {dst_ext, src_mode_oh}, {w[7], 8'd1 << e_mode});
    chk(illegal == e_ill, "R9", illegal, e_ill);
  endtask

  initial begin
    total = 0;
    bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    insn_word = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // initial word 0: R1 fields all zero, R6 register mode on r0
    chk(src_mode == 3'd0 && !const_ok && !src_ext && !illegal, "R6",
        {src_mode, const_ok, src_ext, illegal}, 6'd0);
    // full sweep of every instruction word
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      insn_word = 16'(i);
      @(negedge clk);
      check_word(16'(i));
    end
    // boundary: opcode nibble 3 vs 4 with r3 register-mode destination (R9)
    @(posedge clk);
    insn_word = 16'h3003;
    @(negedge clk);
    chk(illegal == 1'b0, "R9", illegal, 1'b0);
    @(posedge clk);
    insn_word = 16'h4003;
    @(negedge clk);
    chk(illegal == 1'b1, "R9", illegal, 1'b1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule